// File: doc/BRIEF.md
# Critical-Doubleword-First Burst Sequencer

This block sequences one cache-line transfer on a 64-bit bus. A line is 32 bytes, so it moves as four doubleword beats, or as one beat when the request is a single-beat transfer. For a cache-miss fill, whether instruction or data, the first beat carries the doubleword that was asked for. The following beats wrap around the line, so a request that lands in doubleword 2 is served in the order 2, 3, 0, 1. Every other kind of burst moves the line in plain ascending order from doubleword 0.

A request carries an address, a kind flag (miss fill or other burst) and a single-beat flag. The request is taken only while the sequencer is idle. The sequencer then drives the following outputs:

- a transfer-burst indicator;
- the aligned start address;
- the index of the doubleword on the bus in the current beat.

Each beat-acknowledge moves the sequencer to the next doubleword. For a miss fill, a critical pulse follows the first acknowledge, so the requester can restart before the fill is complete. A done pulse follows the final acknowledge.

Top module: `burst_seq_top`

## Requirements
- R1: In reset and right after it, req_ready is 1, and busy, bus_burst, bus_addr, beat_idx, beat_crit and xfer_done are all 0.
- R2: req_ready is 1 only while no transfer is in progress. A request is accepted on a clock edge where req_valid and req_ready are both 1, and busy is 1 from the next cycle. A request presented while busy is ignored: bus_addr and the transfer in progress do not change.
- R3: bus_burst is 1 for a four-beat transfer (req_single = 0) and 0 for a single-beat transfer (req_single = 1). It holds its value for the whole transfer.
- R4: For a miss fill (req_miss = 1, req_single = 0), bus_addr is the request address with bits 2..0 cleared. The first beat_idx is request address bits 4..3.
- R5: During a miss fill, each acknowledged beat that is not the last one increments beat_idx by 1, modulo 4. A start at index 2 gives the order 2, 3, 0, 1.
- R6: For any other burst (req_miss = 0, req_single = 0), bus_addr is the request address with bits 4..0 cleared. The beat indices are 0, 1, 2, 3 in that order.
- R7: For a single-beat transfer, bus_addr is the request address with bits 2..0 cleared and beat_idx is address bits 4..3, whatever req_miss is. The transfer ends after one acknowledged beat.
- R8: beat_crit is 1 for exactly the one cycle after the first acknowledged beat of a miss fill, and 0 at all other times, including for other bursts and single-beat transfers.
- R9: xfer_done is 1 for exactly the one cycle after the last acknowledged beat. In that same cycle busy is 0 and req_ready is 1 again.
- R10: While busy and beat_ack is 0, beat_idx, bus_addr and bus_burst keep their values, and beat_crit and xfer_done stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Transfer request present |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_addr | input | ADDR_W | Byte address of the requested data |
| req_miss | input | 1 | 1 = cache-miss fill (wrapped order), 0 = other burst (linear order) |
| req_single | input | 1 | 1 = single-beat transfer |
| beat_ack | input | 1 | The current beat was transferred |
| busy | output | 1 | A transfer is in progress |
| bus_burst | output | 1 | 1 = four-beat burst, 0 = single beat |
| bus_addr | output | ADDR_W | Aligned start address driven to the bus |
| beat_idx | output | IDX_W | Doubleword index within the line for the current beat |
| beat_crit | output | 1 | One-cycle pulse after the first beat of a miss fill |
| xfer_done | output | 1 | One-cycle pulse after the last beat |

## Verification
The bound checker watches several rules on every cycle:

- the handshake between ready and busy;
- the outputs holding still between acknowledges;
- the modulo-4 step of beat_idx after each non-final acknowledge;
- the single-cycle nature of the critical and done pulses.

Some properties can only be shown by the bench's scenarios, because they depend on request fields and on order across the whole transfer:

- the start address alignment for each kind of request;
- the starting index;
- the full wrapped or linear beat order;
- that a request made mid-transfer is ignored.

The bench sweeps every doubleword offset, both kinds and both single-beat settings, over several upper addresses and several acknowledge gap patterns.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_XFER = 1'b1
  } seq_state_e;

  // Width of a counter that must hold values 0 .. n-1 (at least one bit).
  function automatic int unsigned idx_width(input int unsigned n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/burst_req_decode.sv
module burst_req_decode #(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned DW_BYTES = 8,
  parameter int unsigned LINE_DW  = 4,
  parameter int unsigned IDX_W    = 2
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              miss,
  input  logic              single,
  output logic [ADDR_W-1:0] start_addr,
  output logic [IDX_W-1:0]  start_idx,
  output logic [IDX_W-1:0]  beats_m1,
  output logic              burst,
  output logic              crit_en
);
  localparam int unsigned OFF_W      = burst_seq_pkg::idx_width(DW_BYTES);
  localparam int unsigned LINE_BYTES = DW_BYTES * LINE_DW;
  localparam logic [ADDR_W-1:0] DW_MASK   = ~(ADDR_W'(DW_BYTES - 1));
  localparam logic [ADDR_W-1:0] LINE_MASK = ~(ADDR_W'(LINE_BYTES - 1));

  logic [IDX_W-1:0]  dw_idx;
  logic [ADDR_W-1:0] dw_addr;
  logic [ADDR_W-1:0] line_addr;
  logic              wrap_order;

  assign dw_idx     = addr[OFF_W +: IDX_W];
  assign dw_addr    = addr & DW_MASK;
  assign line_addr  = addr & LINE_MASK;
  // Miss fills and single beats both start at the requested doubleword.
  assign wrap_order = miss | single;

  always_comb begin
    burst    = ~single;
    crit_en  = miss & ~single;
    beats_m1 = single ? '0 : IDX_W'(LINE_DW - 1);
    if (wrap_order) begin
      start_addr = dw_addr;
      start_idx  = dw_idx;
    end else begin
      start_addr = line_addr;
      start_idx  = '0;
    end
  end

endmodule

// File: rtl/burst_beat_track.sv
module burst_beat_track #(
  parameter int unsigned LINE_DW = 4,
  parameter int unsigned IDX_W   = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [IDX_W-1:0] start_idx,
  input  logic [IDX_W-1:0] beats_m1,
  input  logic             step,
  output logic [IDX_W-1:0] idx,
  output logic             last
);
  logic [IDX_W-1:0] remain;
  logic [IDX_W-1:0] idx_next;

  generate
    if ((1 << IDX_W) == LINE_DW) begin : g_pow2
      assign idx_next = idx + 1'b1;
    end else begin : g_modulo
      assign idx_next = (idx == IDX_W'(LINE_DW - 1)) ? '0 : idx + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      idx    <= '0;
      remain <= '0;
    end else if (load) begin
      idx    <= start_idx;
      remain <= beats_m1;
    end else if (step && remain != '0) begin
      idx    <= idx_next;
      remain <= remain - 1'b1;
    end
  end

  assign last = (remain == '0);

endmodule

// File: rtl/burst_seq_top.sv
module burst_seq_top #(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned DW_BYTES = 8,
  parameter int unsigned LINE_DW  = 4,
  parameter int unsigned IDX_W    = burst_seq_pkg::idx_width(LINE_DW)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_miss,
  input  logic              req_single,
  input  logic              beat_ack,
  output logic              busy,
  output logic              bus_burst,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [IDX_W-1:0]  beat_idx,
  output logic              beat_crit,
  output logic              xfer_done
);
  import burst_seq_pkg::*;

  seq_state_e       state;
  logic             accept;
  logic             step;
  logic             last;
  logic             first_pend;
  logic             crit_en_q;
  logic [ADDR_W-1:0] dec_addr;
  logic [IDX_W-1:0]  dec_idx;
  logic [IDX_W-1:0]  dec_beats_m1;
  logic              dec_burst;
  logic              dec_crit;

  burst_req_decode #(
    .ADDR_W  (ADDR_W),
    .DW_BYTES(DW_BYTES),
    .LINE_DW (LINE_DW),
    .IDX_W   (IDX_W)
  ) u_dec (
    .addr      (req_addr),
    .miss      (req_miss),
    .single    (req_single),
    .start_addr(dec_addr),
    .start_idx (dec_idx),
    .beats_m1  (dec_beats_m1),
    .burst     (dec_burst),
    .crit_en   (dec_crit)
  );

  assign accept = req_valid & req_ready;
  assign step   = (state == ST_XFER) & beat_ack;

  burst_beat_track #(
    .LINE_DW(LINE_DW),
    .IDX_W  (IDX_W)
  ) u_track (
    .clk      (clk),
    .rst      (rst),
    .load     (accept),
    .start_idx(dec_idx),
    .beats_m1 (dec_beats_m1),
    .step     (step),
    .idx      (beat_idx),
    .last     (last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      req_ready  <= 1'b1;
      bus_burst  <= 1'b0;
      bus_addr   <= '0;
      first_pend <= 1'b0;
      crit_en_q  <= 1'b0;
      beat_crit  <= 1'b0;
      xfer_done  <= 1'b0;
    end else begin
      beat_crit <= 1'b0;
      xfer_done <= 1'b0;
      if (accept) begin
        state      <= ST_XFER;
        req_ready  <= 1'b0;
        bus_burst  <= dec_burst;
        bus_addr   <= dec_addr;
        first_pend <= 1'b1;
        crit_en_q  <= dec_crit;
      end else if (step) begin
        first_pend <= 1'b0;
        beat_crit  <= first_pend & crit_en_q;
        if (last) begin
          state     <= ST_IDLE;
          req_ready <= 1'b1;
          xfer_done <= 1'b1;
        end
      end
    end
  end

  assign busy = (state == ST_XFER);

endmodule

// File: rtl/burst_seq_checks.sv
module burst_seq_checks #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IDX_W  = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              beat_ack,
  input logic              busy,
  input logic              bus_burst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [IDX_W-1:0]  beat_idx,
  input logic              beat_crit,
  input logic              xfer_done
);

  assert_ready_idle_R2: assert property (@(posedge clk) disable iff (rst)
    busy |-> !req_ready);

  assert_accept_R2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> busy);

  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (busy && !beat_ack) |=> ($stable(beat_idx) && $stable(bus_addr) &&
                             $stable(bus_burst) && !beat_crit && !xfer_done));

  assert_burst_stable_R3: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(bus_burst));

  assert_wrap_step_R5: assert property (@(posedge clk) disable iff (rst)
    (busy && beat_ack) |=> (!busy || beat_idx == IDX_W'($past(beat_idx) + 1'b1)));

  assert_crit_origin_R8: assert property (@(posedge clk) disable iff (rst)
    beat_crit |-> ($past(beat_ack) && $past(bus_burst)));

  assert_crit_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    beat_crit |=> !beat_crit);

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (rst)
    xfer_done |-> (req_ready && !busy && $past(beat_ack)));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    xfer_done |=> !xfer_done);

endmodule

bind burst_seq_top burst_seq_checks #(
  .ADDR_W(ADDR_W),
  .IDX_W (IDX_W)
) u_checks (
  .clk      (clk),
  .rst      (rst),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .beat_ack (beat_ack),
  .busy     (busy),
  .bus_burst(bus_burst),
  .bus_addr (bus_addr),
  .beat_idx (beat_idx),
  .beat_crit(beat_crit),
  .xfer_done(xfer_done)
);

// File: tb/burst_seq_top_test.sv
module burst_seq_top_test;
  localparam int ADDR_W = 32;
  localparam int IDX_W  = 2;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [ADDR_W-1:0] req_addr = '0;
  logic              req_miss = 1'b0;
  logic              req_single = 1'b0;
  logic              beat_ack = 1'b0;
  logic              busy;
  logic              bus_burst;
  logic [ADDR_W-1:0] bus_addr;
  logic [IDX_W-1:0]  beat_idx;
  logic              beat_crit;
  logic              xfer_done;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  burst_seq_top #(.ADDR_W(ADDR_W)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_miss(req_miss), .req_single(req_single),
    .beat_ack(beat_ack), .busy(busy), .bus_burst(bus_burst),
    .bus_addr(bus_addr), .beat_idx(beat_idx), .beat_crit(beat_crit),
    .xfer_done(xfer_done)
  );

  always #2 clk = ~clk;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_xfer(input logic [31:0] a, input bit m, input bit s,
                          input int gap, input bit poke);
    logic [31:0] exp_addr;
    int start;
    int n;
    string tag;
    exp_addr = (s || m) ? (a & ~32'h7) : (a & ~32'h1f);
    start    = (s || m) ? int'(a[4:3]) : 0;
    n        = s ? 1 : 4;
    tag      = s ? "R7" : (m ? "R4" : "R6");
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_miss = m; req_single = s;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R2 busy after accept", busy, 1);
    chk("R2 ready low while busy", req_ready, 0);
    chk("R3 burst flag", bus_burst, !s);
    chk({tag, " start address"}, bus_addr, exp_addr);
    chk({tag, " first index"}, beat_idx, start);
    for (int b = 0; b < n; b++) begin
      for (int g = 0; g < gap; g++) begin
        if (poke) begin
          req_valid = 1'b1; req_addr = ~a; req_miss = !m; req_single = !s;
        end
        @(negedge clk);
        req_valid = 1'b0;
        chk("R10 index held", beat_idx, (start + b) % 4);
        chk("R10 no pulses", {beat_crit, xfer_done}, 0);
        if (poke) begin
          chk("R2 mid request ignored addr", bus_addr, exp_addr);
          chk("R2 mid request ready", req_ready, 0);
          chk("R3 burst unchanged", bus_burst, !s);
        end
      end
      beat_ack = 1'b1;
      @(negedge clk);
      beat_ack = 1'b0;
      chk("R8 critical pulse", beat_crit, (b == 0 && m && !s));
      chk("R9 done pulse", xfer_done, (b == n - 1));
      if (b < n - 1) begin
        chk(m ? "R5 wrapped index" : "R6 linear index", beat_idx, (start + b + 1) % 4);
      end else begin
        chk("R9 ready back", req_ready, 1);
        chk("R9 busy cleared", busy, 0);
      end
    end
    @(negedge clk);
    chk("R8 critical cleared", beat_crit, 0);
    chk("R9 done single cycle", xfer_done, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 ready in reset", req_ready, 1);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 ready", req_ready, 1);
    chk("R1 busy", busy, 0);
    chk("R1 burst", bus_burst, 0);
    chk("R1 addr", bus_addr, 0);
    chk("R1 idx", beat_idx, 0);
    chk("R1 pulses", {beat_crit, xfer_done}, 0);
    for (int u = 0; u < 3; u++) begin
      for (int mi = 0; mi < 2; mi++) begin
        for (int si = 0; si < 2; si++) begin
          for (int off = 0; off < 32; off += 3) begin
            logic [31:0] a;
            a = (32'h1234_5600 * (u + 1)) ^ (u * 32'h8000_0040) | 32'(off);
            a[4:0] = 5'(off);
            run_xfer(a, mi[0], si[0], (off + mi + u) % 3, (off % 2) == 1);
          end
        end
      end
    end
    // Explicit wrap example: doubleword 2 gives 2,3,0,1.
    run_xfer(32'hABCD_EF14, 1'b1, 1'b0, 0, 1'b0);
    // Back-to-back requests with no gap.
    run_xfer(32'h0000_0018, 1'b1, 1'b0, 0, 1'b0);
    run_xfer(32'h0000_0018, 1'b0, 1'b0, 0, 1'b0);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule